// File: doc/BRIEF.md
# Double-Rate Two-Beat Synchronous SRAM Core

This block models the command and data path of a synchronous static RAM that moves two data words per access, one on each half of a clock period. It is built around a single clock that runs at twice the command rate. An internal phase bit splits each command period into a command phase and a complementary phase, and the block reports this phase on `k_phase`. A command is taken only on command-phase edges. It carries an address and a direction, and every access moves a pair of words.

Write data follows a write command on the next two edges: first on the complementary phase, then on the next command phase. Each word comes with active-low per-lane write masks. The storage is split into two equal halves. The first beat of every burst lives in one half and the second beat in the other. Read data comes back two and a half command periods after the read command, as two back-to-back beats marked by a valid flag. On every other cycle the data output is held at zero. Commands may arrive on every command-phase edge with no gaps.

Top module: `ddr_burst2_sram`

## Requirements
- R1: A command is accepted only on a command-phase edge (`k_phase` high before the edge) with `load_n` low. With `load_n` high, or on a complementary-phase edge, no read is started and no stored word changes.
- R2: For an accepted command, `rd_wr` high selects a read and `rd_wr` low selects a write, for the address on `addr` at that same edge.
- R3: A write moves exactly two words. The first is taken from `wdata` on the complementary-phase edge right after the command and goes into the first-beat half. The second is taken on the following command-phase edge and goes into the second-beat half.
- R4: `wmask_n` is active low and is sampled on the same edge as the word it qualifies. Bit i covers data bits [9i+8:9i]. A lane whose mask bit is high keeps its stored value.
- R5: A read accepted on edge e drives the first-beat word on `rdata` from edge e+5 and the second-beat word from edge e+6, counting edges of `clk`.
- R6: `rvalid` is high in exactly the cycles in which a read beat is being driven, and every first beat is followed directly by its second beat.
- R7: While `rvalid` is low, `rdata` is zero.
- R8: A new command can be accepted on every command-phase edge. Reads issued on consecutive command edges produce an unbroken stream of beats.
- R9: A read returns every byte of any earlier write to the same address, including a write whose second beat is stored on the read's own edge.
- R10: Reset clears both halves and the outputs. After reset, `k_phase` is high and then toggles on every edge, so the first edge after reset is a command-phase edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the command rate |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low command strobe, sampled on command-phase edges |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Burst address |
| wdata | input | LANES*LANE_W | Write data beat |
| wmask_n | input | LANES | Active-low lane write masks for the current beat |
| k_phase | output | 1 | High when the next edge is a command-phase edge |
| rdata | output | LANES*LANE_W | Read data beat, zero when idle |
| rvalid | output | 1 | High while a read beat is driven |

## Verification
The hardest case to reach is a read that lands on the same edge on which the second beat of an earlier write to the same address is being stored. A read right after the write is not enough; the two commands must sit on adjacent command edges with matching addresses. A directed scenario issues a masked write followed at once by a read of that address, and repeats this under back-to-back streams. Other stimulus holds `load_n` low on complementary-phase edges, then reads the affected addresses back to show that nothing changed.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
    typedef enum logic {PH_K = 1'b0, PH_KB = 1'b1} phase_e;
    // command-rate pipeline stages between capture and the output register
    localparam int RD_K_STAGES = 3;
    localparam int BEATS       = 2;
endpackage

// File: rtl/ddr2b_cmd.sv
module ddr2b_cmd
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_k,
    output logic              we0,
    output logic [ADDR_W-1:0] waddr0,
    output logic              we1,
    output logic [ADDR_W-1:0] waddr1,
    output logic              rd_cap,
    output logic [ADDR_W-1:0] raddr
);
    typedef struct packed {
        phase_e            phase;
        logic              wr1_v;
        logic [ADDR_W-1:0] wr1_a;
        logic              wr2_v;
        logic [ADDR_W-1:0] wr2_a;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    assign is_k = (st_q.phase == PH_K);

    always_comb begin
        st_d       = st_q;
        st_d.phase = is_k ? PH_KB : PH_K;
        st_d.wr1_v = is_k && !load_n && !rd_wr;
        st_d.wr1_a = addr;
        st_d.wr2_v = !is_k && st_q.wr1_v;
        st_d.wr2_a = st_q.wr1_a;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we0    = st_q.wr1_v;
    assign waddr0 = st_q.wr1_a;
    assign we1    = st_q.wr2_v;
    assign waddr1 = st_q.wr2_a;
    assign rd_cap = is_k && !load_n && rd_wr;
    assign raddr  = addr;

    // R1: complementary-phase edges never start a write
    a_r1_kbar_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !is_k |=> !we0);
    // R3: the second beat always follows a first beat
    a_r3_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
        we1 |-> $past(we0));
endmodule

// File: rtl/ddr2b_bank.sv
module ddr2b_bank #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          wmask_n,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [DATA_W-1:0] word_t;

    word_t mem_d [DEPTH];
    word_t mem_q [DEPTH];
    word_t merged;

    function automatic word_t lane_merge(word_t old_w, word_t new_w, logic [LANES-1:0] m_n);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (!m_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    always_comb begin
        merged = lane_merge(mem_q[waddr], wdata, wmask_n);
        mem_d  = mem_q;
        if (we) mem_d[waddr] = merged;
        // forward a beat stored on the same edge as the read snapshot
        rdata = (we && (waddr == raddr)) ? merged : mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/ddr2b_rdpipe.sv
module ddr2b_rdpipe
    import ddr2b_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_k,
    input  logic              cap_v,
    input  logic [DATA_W-1:0] cap_w0,
    input  logic [DATA_W-1:0] cap_w1,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int NST = RD_K_STAGES;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
    } stg_t;

    typedef struct packed {
        stg_t [NST-1:0]    st;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } pipe_t;

    pipe_t p_d, p_q;
    stg_t  last_q;

    assign last_q = p_q.st[NST-1];

    always_comb begin
        p_d        = p_q;
        p_d.rvalid = last_q.v;
        if (is_k) begin
            p_d.st[0] = '{v: cap_v, w0: cap_w0, w1: cap_w1};
            for (int i = 1; i < NST; i++) p_d.st[i] = p_q.st[i-1];
            p_d.rdata = last_q.v ? last_q.w1 : '0;
        end else begin
            p_d.rdata = last_q.v ? last_q.w0 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rdata  = p_q.rdata;
    assign rvalid = p_q.rvalid;

    // R5: first beat visible after the fifth edge past the command edge
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (is_k && cap_v) |-> ##6 rvalid);
    // R6: a first beat (driven during the command phase) is followed by its second
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && is_k) |=> rvalid);
    // R7: idle output is zero
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));
endmodule

// File: rtl/ddr_burst2_sram.sv
module ddr_burst2_sram
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_n,
    input  logic                    rd_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wmask_n,
    output logic                    k_phase,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    logic              is_k;
    logic              rd_cap;
    logic [ADDR_W-1:0] raddr;
    logic              we_b    [BEATS];
    logic [ADDR_W-1:0] waddr_b [BEATS];
    logic [DATA_W-1:0] rd_b    [BEATS];

    ddr2b_cmd #(.ADDR_W(ADDR_W)) i_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .rd_wr  (rd_wr),
        .addr   (addr),
        .is_k   (is_k),
        .we0    (we_b[0]),
        .waddr0 (waddr_b[0]),
        .we1    (we_b[1]),
        .waddr1 (waddr_b[1]),
        .rd_cap (rd_cap),
        .raddr  (raddr)
    );

    for (genvar h = 0; h < BEATS; h++) begin : g_half
        ddr2b_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (we_b[h]),
            .waddr   (waddr_b[h]),
            .wdata   (wdata),
            .wmask_n (wmask_n),
            .raddr   (raddr),
            .rdata   (rd_b[h])
        );
    end

    ddr2b_rdpipe #(.DATA_W(DATA_W)) i_rdpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .is_k   (is_k),
        .cap_v  (rd_cap),
        .cap_w0 (rd_b[0]),
        .cap_w1 (rd_b[1]),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    assign k_phase = is_k;

    // R3: the two halves are never written on the same edge
    a_r3_split_halves: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_b[0] && we_b[1]));
endmodule

// File: tb/test_ddr_burst2_sram.sv
module test_ddr_burst2_sram;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          rd_wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NL-1:0] wmask_n = '1;
    logic          k_phase;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    int eidx   = 0;
    bit done   = 0;

    logic [DW-1:0] ref0 [1<<AW];
    logic [DW-1:0] ref1 [1<<AW];
    bit            exp_v [16];
    logic [DW-1:0] exp_d [16];
    bit            pend_v = 0;
    logic [DW-1:0] pend_d;
    logic [NL-1:0] pend_m;

    always #5 clk = ~clk;

    ddr_burst2_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_ddr_burst2_sram (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .wmask_n(wmask_n), .k_phase(k_phase), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [NL-1:0] m);
        logic [DW-1:0] r = o;
        for (int i = 0; i < NL; i++) if (!m[i]) r[i*LW +: LW] = n[i*LW +: LW];
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s edge %0d actual %h expected %h", tag, eidx, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        int s = eidx % 16;
        logic [DW-1:0] ed = exp_v[s] ? exp_d[s] : '0;
        chk(rvalid === exp_v[s] && rdata === ed, tag, {rvalid, rdata}, {exp_v[s], ed});
        exp_v[s] = 0;
    endtask

    // one command period; called at a negedge just before a command-phase edge
    task automatic kcycle(input bit ld, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NL-1:0] m0, input logic [NL-1:0] m1,
                          input bit kb_noise, input string tag);
        logic [DW-1:0] b0d = '0;
        logic [NL-1:0] b0m = '1;
        chk(k_phase === 1'b1, "R10 phase", {{DW{1'b0}}, k_phase}, {{DW{1'b0}}, 1'b1});
        load_n = !ld; rd_wr = rd; addr = a;
        if (pend_v) begin wdata = pend_d; wmask_n = pend_m; pend_v = 0; end
        else        begin wdata = rnd_word(); wmask_n = '1; end
        if (ld && rd) begin
            exp_v[(eidx+5)%16] = 1; exp_d[(eidx+5)%16] = ref0[a];
            exp_v[(eidx+6)%16] = 1; exp_d[(eidx+6)%16] = ref1[a];
        end
        if (ld && !rd) begin
            ref0[a] = merge(ref0[a], d0, m0);
            ref1[a] = merge(ref1[a], d1, m1);
            pend_v = 1; pend_d = d1; pend_m = m1;
            b0d = d0; b0m = m0;
        end
        @(posedge clk); @(negedge clk);
        check_out(tag); eidx++;
        // complementary phase: first write beat, optional stray command
        load_n = !kb_noise; rd_wr = 1'b0; addr = kb_noise ? a + 1'b1 : '0;
        if (ld && !rd) begin wdata = b0d; wmask_n = b0m; end
        else begin wdata = kb_noise ? rnd_word() : '0; wmask_n = kb_noise ? '0 : '1; end
        @(posedge clk); @(negedge clk);
        check_out(tag); eidx++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) kcycle(0, 0, '0, '0, '0, '1, '1, 0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [NL-1:0] m0, input logic [NL-1:0] m1, input string tag);
        kcycle(1, 0, a, d0, d1, m0, m1, 0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        kcycle(1, 1, a, '0, '0, '1, '1, 0, tag);
    endtask

    // R10: reset state, zeroed array
    task automatic t_reset();
        chk(rvalid === 1'b0 && rdata === '0, "R10 reset", {rvalid, rdata}, '0);
        chk(k_phase === 1'b1, "R10 first edge", {{DW{1'b0}}, k_phase}, {{DW{1'b0}}, 1'b1});
        rd(4'd3, "R10 zero array");
        idle(4, "R10 R7 idle");
    endtask

    // R2 R3 R5 R6: full-mask write then read, two separate beats
    task automatic t_basic();
        wr(4'd1, 36'h123456789, 36'hFEDCBA987, 4'h0, 4'h0, "R2 R3 write");
        idle(1, "R3");
        rd(4'd1, "R5 R6 read");
        idle(4, "R5 R6 beats");
    endtask

    // R4: each lane masked alone on each beat
    task automatic t_masks();
        for (int l = 0; l < NL; l++) begin
            wr(4'd2, rnd_word(), rnd_word(), ~(4'b1 << l), 4'b1 << l, "R4 lanes");
        end
        rd(4'd2, "R4 readback");
        wr(4'd2, rnd_word(), rnd_word(), 4'hF, 4'hF, "R4 all masked");
        rd(4'd2, "R4 unchanged");
        idle(4, "R4");
    endtask

    // R8: writes on every command edge, then an unbroken read stream
    task automatic t_stream();
        for (int i = 0; i < 8; i++) wr(i[AW-1:0], rnd_word(), rnd_word(), '0, '0, "R8 writes");
        for (int i = 0; i < 8; i++) rd(i[AW-1:0], "R8 read stream");
        idle(4, "R8 drain");
    endtask

    // R9: read directly after write of the same address
    task automatic t_hazard();
        for (int i = 0; i < 6; i++) begin
            wr(4'd9, rnd_word(), rnd_word(), 4'($urandom), 4'($urandom), "R9 write");
            rd(4'd9, "R9 forward");
        end
        idle(4, "R9");
    endtask

    // R1: strobe high or strobes on the complementary phase do nothing
    task automatic t_ignore();
        for (int i = 0; i < 4; i++) begin
            load_n = 1'b1;
            kcycle(0, 1, 4'd5, '0, '0, '1, '1, 1, "R1 stray");
        end
        kcycle(0, 0, 4'd8, '0, '0, '1, '1, 1, "R1 stray write");
        for (int a = 0; a < 10; a++) rd(a[AW-1:0], "R1 R2 unchanged");
        idle(4, "R1 R7");
    endtask

    // mixed random traffic
    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a = 4'($urandom);
            case ($urandom % 3)
                0: wr(a, rnd_word(), rnd_word(), 4'($urandom), 4'($urandom), "R4 R9 random");
                1: rd(a, "R5 R6 R8 random");
                default: kcycle(0, $urandom % 2, a, '0, '0, '1, '1, $urandom % 2, "R1 random");
            endcase
        end
        idle(5, "R6 R7 drain");
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin ref0[i] = '0; ref1[i] = '0; end
        for (int i = 0; i < 16; i++) begin exp_v[i] = 0; exp_d[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_masks();
        t_stream();
        t_hazard();
        t_ignore();
        t_random();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule